// File: doc/BRIEF.md
# Strobe-Refreshed Watchdog Reset Generator

This block supervises a processor through a single strobe line. While the processor runs, its software must drive the strobe from high to low at regular intervals. A falling edge restarts a timeout counter. If the counter reaches the selected period before an edge arrives, the block drives a reset pulse of fixed length on two complementary outputs. When the pulse ends, a fresh timeout period begins at zero. No control can switch the watchdog off.

Time is counted in ticks of a one-millisecond enable input, so the block runs on any system clock. A two-bit select input picks one of three timeout periods. It stands in for a pin that can be tied low, left open or tied high. The select is read only when a new timeout period starts. A manual reset request starts the same reset pulse at once. After power-on reset the block starts in the reset-active phase, so the controlled processor is held in reset first. While reset is active the strobe is ignored.

Top module: `strobe_wdog`

## Requirements
- R1: A high-to-low transition of `strobe`, seen by the synchronizer in the watch phase, restarts the timeout from zero. The counter clears on the second clock edge after the first edge that samples the low level. With a tick on every clock, `rst_hi` then stays low for exactly P+2 samples after the drop, where P is the selected period in ticks.
- R2: A steady high level, a steady low level or a rising edge on `strobe` never restarts the timeout.
- R3: In the watch phase without a refresh, reset is asserted on the P-th tick after the period starts. The encoding of `period_sel` is: 2'b00 gives 150 ticks, 2'b01 and 2'b11 give 600 ticks, 2'b10 gives 1200 ticks.
- R4: A reset pulse lasts exactly `PULSE_TICKS` ticks (default 250). After it the block returns to the watch phase.
- R5: While reset is active, falling edges on `strobe` have no effect. On release, the timeout starts from zero.
- R6: A high `man_req` asserts reset on the next clock edge and restarts the pulse count from zero, also during an active pulse. It takes priority over a strobe refresh in the same cycle.
- R7: `rst_n` is always the complement of `rst_hi`.
- R8: `period_sel` is sampled only when a period starts, that is on release or on refresh. A change in the middle of a period takes effect with the next period.
- R9: Both counters advance only on clocks where `tick_1ms` is high. Without ticks the reset state does not change, except through `man_req`.
- R10: When a refresh and a timeout fall on the same clock edge, the refresh wins and reset stays inactive.
- R11: While the synchronous `rst` is high, `rst_hi` is 1 and `rst_n` is 0. After `rst` falls, the block begins with a full reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| tick_1ms | input | 1 | One-cycle enable pulse per millisecond, the timebase for both counters |
| period_sel | input | 2 | Timeout period select (see R3) |
| strobe | input | 1 | Asynchronous refresh strobe; a falling edge refreshes |
| man_req | input | 1 | Manual reset request |
| rst_hi | output | 1 | Active-high reset to the processor |
| rst_n | output | 1 | Active-low reset, complement of `rst_hi` |

## Verification
Two functions can fall on the same clock edge: the timeout can expire on the very edge at which a synchronized strobe edge arrives, and a manual request can coincide with a refresh. The bench provokes the first collision by dropping the strobe exactly three samples before the expiry sample, so that the detected edge lands on the expiring tick. It then requires reset to stay low for a full new period. For the second collision it times a strobe drop so that the detected edge lands on the same edge as a one-cycle manual request, and it requires reset to be active on the following sample.

// File: rtl/strobe_wdog_pkg.sv
package strobe_wdog_pkg;

    typedef enum logic {
        PH_HOLD  = 1'b0,
        PH_WATCH = 1'b1
    } wd_phase_e;

    typedef struct packed {
        logic refresh;
        logic expire;
        logic rel;
    } wd_ctl_t;

    localparam logic [1:0] SEL_TIED_LOW  = 2'b00;
    localparam logic [1:0] SEL_TIED_HIGH = 2'b10;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned pick_period(input logic [1:0] sel,
                                                input int unsigned lo,
                                                input int unsigned mid,
                                                input int unsigned hi);
        case (sel)
            SEL_TIED_LOW:  return lo;
            SEL_TIED_HIGH: return hi;
            default:       return mid;
        endcase
    endfunction

endpackage

// File: rtl/wd_strobe_edge.sv
module wd_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic fall
);
    logic s_meta;
    logic s_sync;
    logic s_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_meta <= 1'b0;
            s_sync <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_meta <= strobe;
            s_sync <= s_meta;
            s_prev <= s_sync;
        end
    end

    assign fall = s_prev & ~s_sync;
endmodule

// File: rtl/wd_tick_counter.sv
module wd_tick_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/strobe_wdog.sv
module strobe_wdog
    import strobe_wdog_pkg::*;
#(
    parameter int unsigned PER_LOW     = 150,
    parameter int unsigned PER_OPEN    = 600,
    parameter int unsigned PER_HIGH    = 1200,
    parameter int unsigned PULSE_TICKS = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1ms,
    input  logic [1:0] period_sel,
    input  logic       strobe,
    input  logic       man_req,
    output logic       rst_hi,
    output logic       rst_n
);
    localparam int unsigned MAXV = max_of(max_of(PER_LOW, PER_OPEN), max_of(PER_HIGH, PULSE_TICKS));
    localparam int unsigned CW   = $clog2(MAXV + 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_TICKS - 1);

    wd_phase_e     phase_q;
    wd_ctl_t       ctl;
    logic          in_watch;
    logic          fall;
    logic [CW-1:0] period_q;
    logic [CW-1:0] period_nx;
    logic [CW-1:0] w_count;
    logic [CW-1:0] p_count;
    logic          w_done;
    logic          p_done;
    logic          w_clear;
    logic          p_clear;

    wd_strobe_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .fall   (fall)
    );

    assign in_watch  = (phase_q == PH_WATCH);
    assign period_nx = CW'(pick_period(period_sel, PER_LOW, PER_OPEN, PER_HIGH));

    assign w_done = tick_1ms && (w_count == period_q - 1'b1);
    assign p_done = tick_1ms && (p_count == PULSE_LAST);

    always_comb begin
        ctl.refresh = in_watch && fall && !man_req;
        ctl.expire  = in_watch && w_done && !fall && !man_req;
        ctl.rel     = !in_watch && p_done && !man_req;
    end

    assign w_clear = !in_watch || fall || man_req;
    assign p_clear = in_watch || man_req || p_done;

    wd_tick_counter #(.W(CW)) u_watch_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (w_clear),
        .step  (tick_1ms),
        .count (w_count)
    );

    wd_tick_counter #(.W(CW)) u_pulse_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (p_clear),
        .step  (tick_1ms),
        .count (p_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_HOLD;
            period_q <= '0;
        end else if (man_req || ctl.expire) begin
            phase_q <= PH_HOLD;
        end else if (ctl.rel) begin
            phase_q  <= PH_WATCH;
            period_q <= period_nx;
        end else if (ctl.refresh) begin
            period_q <= period_nx;
        end
    end

    assign rst_hi = !in_watch;
    assign rst_n  = in_watch;
endmodule

// File: rtl/strobe_wdog_chk.sv
module strobe_wdog_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         man_req,
    input logic         fall,
    input logic         in_watch,
    input logic         rst_hi,
    input logic         rst_n,
    input logic [W-1:0] w_count,
    input logic [W-1:0] period
);
    p_complement_r7: assert property (@(posedge clk) disable iff (rst)
        rst_hi != rst_n);

    p_manual_r6: assert property (@(posedge clk) disable iff (rst)
        man_req |=> rst_hi);

    p_expire_r3: assert property (@(posedge clk) disable iff (rst)
        (in_watch && tick && !fall && !man_req && w_count == W'(period - 1'b1)) |=> rst_hi);

    p_no_early_r3: assert property (@(posedge clk) disable iff (rst)
        (in_watch && !man_req && !(tick && w_count == W'(period - 1'b1))) |=> !rst_hi);

    p_refresh_r1: assert property (@(posedge clk) disable iff (rst)
        (in_watch && fall && !man_req) |=> (!rst_hi && w_count == '0));

    p_fresh_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(in_watch) |-> (w_count == '0));

    p_period_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (in_watch && !fall) |=> $stable(period));

    p_tick_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (!tick && !man_req) |=> $stable(rst_hi));
endmodule

bind strobe_wdog strobe_wdog_chk #(.W(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_1ms),
    .man_req  (man_req),
    .fall     (fall),
    .in_watch (in_watch),
    .rst_hi   (rst_hi),
    .rst_n    (rst_n),
    .w_count  (w_count),
    .period   (period_q)
);

// File: tb/strobe_wdog_bench.sv
module strobe_wdog_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1ms = 1'b1;
    logic [1:0] period_sel = 2'b00;
    logic       strobe = 1'b1;
    logic       man_req = 1'b0;
    logic       rst_hi;
    logic       rst_n;

    int total = 0;
    int bad = 0;
    int n;

    localparam int PULSE = 250;

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] pre;
        logic [15:0] per;
    } vec_t;

    // sel, samples after period start before the drop, expected new period
    localparam vec_t VEC [5] = '{
        '{2'd0, 16'd10,  16'd150},
        '{2'd1, 16'd147, 16'd600},
        '{2'd2, 16'd100, 16'd1200},
        '{2'd3, 16'd0,   16'd600},
        '{2'd0, 16'd597, 16'd150}
    };

    always #5 clk = ~clk;

    strobe_wdog u_strobe_wdog (
        .clk        (clk),
        .rst        (rst),
        .tick_1ms   (tick_1ms),
        .period_sel (period_sel),
        .strobe     (strobe),
        .man_req    (man_req),
        .rst_hi     (rst_hi),
        .rst_n      (rst_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic meas_high(output int cnt);
        cnt = 0;
        while (rst_hi === 1'b1 && cnt < 6000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic meas_low(output int cnt);
        cnt = 0;
        while (rst_hi === 1'b0 && cnt < 6000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 rst_hi in reset", int'(rst_hi), 1);
        chk("R7 rst_n in reset", int'(rst_n), 0);
        rst = 1'b0;
        meas_high(n);
        chk("R4 R11 power-on pulse length", n, PULSE);

        for (int i = 0; i < 5; i++) begin
            period_sel = VEC[i].sel;
            repeat (int'(VEC[i].pre)) @(negedge clk);
            chk("R10 still watching before drop", int'(rst_hi), 0);
            strobe = 1'b0;
            repeat (5) @(negedge clk);
            strobe = 1'b1; // R2 rising edge must not refresh
            repeat (int'(VEC[i].per) - 3) @(negedge clk);
            chk("R1 R3 no reset before period end", int'(rst_hi), 0);
            @(negedge clk);
            chk("R3 reset at period end", int'(rst_hi), 1);
            chk("R7 complement", int'(rst_n), 0);
            meas_high(n);
            chk("R4 pulse length", n, PULSE);
        end

        meas_low(n);
        chk("R2 steady high gives full period", n, 150);
        repeat (100) @(negedge clk);
        strobe = 1'b0;
        meas_high(n);
        chk("R5 strobe in reset ignored", n, PULSE - 100);
        meas_low(n);
        chk("R2 R5 steady low, fresh period", n, 150);

        meas_high(n);
        tick_1ms = 1'b0;
        repeat (300) @(negedge clk);
        chk("R9 no ticks no timeout", int'(rst_hi), 0);
        tick_1ms = 1'b1;
        meas_low(n);
        chk("R9 count resumes", n, 150);

        meas_high(n);
        period_sel = 2'b10;
        meas_low(n);
        chk("R8 select change waits", n, 150);
        meas_high(n);
        period_sel = 2'b00;
        meas_low(n);
        chk("R8 select taken at release", n, 1200);

        meas_high(n);
        repeat (20) @(negedge clk);
        man_req = 1'b1;
        @(negedge clk);
        man_req = 1'b0;
        chk("R6 manual asserts reset", int'(rst_hi), 1);
        meas_high(n);
        chk("R6 manual pulse length", n, PULSE);

        strobe = 1'b1;
        repeat (5) @(negedge clk);
        strobe = 1'b0;
        repeat (2) @(negedge clk);
        man_req = 1'b1;
        @(negedge clk);
        man_req = 1'b0;
        chk("R6 manual beats refresh", int'(rst_hi), 1);
        repeat (100) @(negedge clk);
        man_req = 1'b1;
        @(negedge clk);
        man_req = 1'b0;
        meas_high(n);
        chk("R6 manual restarts pulse", n, PULSE);
        chk("R7 complement in watch", int'(rst_n), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule